// File: doc/BRIEF.md
# Motor Bridge Serial Control Port

This block is the serial slave of a motor-bridge controller. It runs an 8-bit full-duplex exchange. A host writes a control word that sets the bridge's current limit, chopper off-time, decay mode and overvoltage lockout. In the same exchange the host reads a diagnosis word assembled from the fault inputs. The block brings the serial pins into the system clock domain through two-flop synchronisers and edge detectors, so the system clock must run at least four times faster than the serial clock.

A word takes effect only when chip select is released after at least eight serial clocks. If the frame runs longer than eight clocks, the last eight bits received are kept, which allows several devices to be chained. Control bit 7 is not stored. It produces a one-cycle pulse that clears latched faults elsewhere. When the host lowers chip select and sends no clocks, the block puts the live error flag on the serial output. This gives the host a quick health check.

Top module: `mbc_serial_ctrl`

## Requirements
- R1: After reset all control outputs are 0 and status_clr_o is 0, and they stay so until the first complete transfer.
- R2: sdo_en_o is 1 exactly while csn_i is low; while csn_i is high the output is released.
- R3: Data on sdi_i is sampled on falling serial-clock edges, least significant bit first. On release of chip select after 8 or more clocks, the received word is decoded as follows: bit 6 is the overvoltage lockout enable, bits 4:3 the off-time select, bit 2 the decay mode (1 = fast), and bits 1:0 the current-limit select. Bit 5 has no effect.
- R4: The diagnosis word is captured when chip select falls and is shifted out least significant bit first, one bit per rising serial-clock edge. Its layout is: bit 7 supply fail, bit 6 constant 1, bit 5 short to supply or across the load, bit 4 short to ground, bit 3 open load, bits 2:1 temperature level, bit 0 error flag.
- R5: The error flag is the OR of supply fail, short to supply, short to ground, open load, and a nonzero temperature level. The constant bit 6 does not contribute.
- R6: While chip select is low and no serial clock has been seen, sdo_o follows the live error flag. Releasing chip select after such a frame leaves the controls unchanged.
- R7: A committed word with bit 7 set gives exactly one cycle of status_clr_o. With bit 7 clear there is no pulse. Bit 7 drives no stored output.
- R8: A frame with fewer than 8 falling serial-clock edges leaves the controls unchanged.
- R9: In a frame longer than 8 clocks, the bit received on falling edge k appears on sdo_o after rising edge k+8, and the last 8 bits received are committed.
- R10: Serial-clock activity while chip select is high does not shift data and does not change the controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low (power-on or inhibit) |
| sclk_i | input | 1 | Serial clock pin, idles low |
| csn_i | input | 1 | Chip select pin, active low |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_en_o | output | 1 | Output enable for the tristate pad |
| supply_fail_i | input | 1 | Latched supply fault |
| short_supply_i | input | 1 | Latched short to supply or across the load |
| short_gnd_i | input | 1 | Latched short to ground |
| open_load_i | input | 1 | Latched open load |
| temp_level_i | input | 2 | Temperature level, 0 = normal |
| ov_lock_en_o | output | 1 | Overvoltage lockout enable |
| off_time_sel_o | output | 2 | Chopper off-time select |
| fast_decay_o | output | 1 | 1 = fast decay, 0 = slow decay |
| cur_limit_sel_o | output | 2 | Chopper current-limit select |
| status_clr_o | output | 1 | One-cycle clear of latched status |

## Verification
A wrong bit counter or a misplaced shift shows up at the ports in two ways. The diagnosis bits come out reordered or shifted within the same frame. The controls take a wrong or stale value a few system cycles after chip select rises. A broken peek path shows a wrong level on sdo_o within a few cycles of chip select falling. A mishandled bit 7 shows either a missing clear pulse or a doubled one right after the commit. Chained frames check that data written in comes out exactly eight clocks later.

// File: rtl/mbc_serial_pkg.sv
package mbc_serial_pkg;
  localparam int FRAME_W = 8;
  localparam int CLR_BIT = 7;
  localparam int OVL_BIT = 6;

  typedef struct packed {
    logic       ov_lock_en;
    logic [1:0] off_time;
    logic       fast_decay;
    logic [1:0] cur_limit;
  } ctrl_t;

  function automatic ctrl_t decode_ctrl(input logic [FRAME_W-1:0] w);
    ctrl_t c;
    c.ov_lock_en = w[OVL_BIT];
    c.off_time   = w[4:3];
    c.fast_decay = w[2];
    c.cur_limit  = w[1:0];
    return c;
  endfunction
endpackage

// File: rtl/mbc_pin_sync.sv
module mbc_pin_sync #(
  parameter int           W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
        s3_q <= RST_VAL[i];
      end else begin
        s1_q <= pin_i[i];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign lvl_o[i]  = s2_q;
    assign rise_o[i] = s2_q & ~s3_q;
    assign fall_o[i] = ~s2_q & s3_q;
  end
endmodule

// File: rtl/mbc_frame_shift.sv
module mbc_frame_shift #(
  parameter int W = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         csn_lvl_i,
  input  logic         csn_fall_i,
  input  logic         csn_rise_i,
  input  logic         sclk_rise_i,
  input  logic         sclk_fall_i,
  input  logic         sdi_i,
  input  logic [W-1:0] diag_i,
  input  logic         live_err_i,
  output logic         sdo_o,
  output logic         commit_o,
  output logic [W-1:0] word_o
);
  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;
  logic          clocked_q, out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q      <= '0;
      cnt_q     <= '0;
      clocked_q <= 1'b0;
      out_q     <= 1'b0;
      commit_o  <= 1'b0;
    end else begin
      commit_o <= 1'b0;
      if (csn_fall_i) begin
        sh_q      <= diag_i;
        cnt_q     <= '0;
        clocked_q <= 1'b0;
      end else if (csn_rise_i) begin
        commit_o  <= (cnt_q == CW'(W));
        clocked_q <= 1'b0;
      end else if (!csn_lvl_i) begin
        if (sclk_rise_i) begin
          out_q     <= sh_q[0];
          clocked_q <= 1'b1;
        end
        if (sclk_fall_i && clocked_q) begin
          sh_q <= {sdi_i, sh_q[W-1:1]};
          if (cnt_q != CW'(W)) cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // peek path: no clock seen yet, show live flag
  assign sdo_o  = clocked_q ? out_q : live_err_i;
  assign word_o = sh_q;

  // R8
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(W));
  // R3
  commit_after_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> csn_lvl_i);
endmodule

// File: rtl/mbc_ctrl_reg.sv
module mbc_ctrl_reg
  import mbc_serial_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               commit_i,
  input  logic [FRAME_W-1:0] word_i,
  output ctrl_t              ctrl_o,
  output logic               clr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      clr_o  <= 1'b0;
    end else begin
      clr_o <= 1'b0;
      if (commit_i) begin
        ctrl_o <= decode_ctrl(word_i);
        clr_o  <= word_i[CLR_BIT];
      end
    end
  end

  // R8
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(ctrl_o));
  // R7
  clr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> !clr_o);
  // R7
  clr_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |-> $past(commit_i));
endmodule

// File: rtl/mbc_serial_ctrl.sv
module mbc_serial_ctrl
  import mbc_serial_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       csn_i,
  input  logic       sdi_i,
  output logic       sdo_o,
  output logic       sdo_en_o,
  input  logic       supply_fail_i,
  input  logic       short_supply_i,
  input  logic       short_gnd_i,
  input  logic       open_load_i,
  input  logic [1:0] temp_level_i,
  output logic       ov_lock_en_o,
  output logic [1:0] off_time_sel_o,
  output logic       fast_decay_o,
  output logic [1:0] cur_limit_sel_o,
  output logic       status_clr_o
);
  localparam int PINS = 3;  // [0] sclk, [1] csn, [2] sdi

  logic [PINS-1:0] lvl, rise, fall;
  logic            err_flag, commit;
  logic [FRAME_W-1:0] diag_word, word;
  ctrl_t           ctrl;

  mbc_pin_sync #(.W(PINS), .RST_VAL(3'b010)) u_sync (
    .clk_i, .rst_ni,
    .pin_i ({sdi_i, csn_i, sclk_i}),
    .lvl_o (lvl),
    .rise_o(rise),
    .fall_o(fall)
  );

  assign err_flag  = supply_fail_i | short_supply_i | short_gnd_i | open_load_i | (|temp_level_i);
  assign diag_word = {supply_fail_i, 1'b1, short_supply_i, short_gnd_i, open_load_i,
                      temp_level_i, err_flag};

  mbc_frame_shift #(.W(FRAME_W)) u_shift (
    .clk_i, .rst_ni,
    .csn_lvl_i  (lvl[1]),
    .csn_fall_i (fall[1]),
    .csn_rise_i (rise[1]),
    .sclk_rise_i(rise[0]),
    .sclk_fall_i(fall[0]),
    .sdi_i      (lvl[2]),
    .diag_i     (diag_word),
    .live_err_i (err_flag),
    .sdo_o      (sdo_o),
    .commit_o   (commit),
    .word_o     (word)
  );

  mbc_ctrl_reg u_ctrl (
    .clk_i, .rst_ni,
    .commit_i(commit),
    .word_i  (word),
    .ctrl_o  (ctrl),
    .clr_o   (status_clr_o)
  );

  assign sdo_en_o        = ~csn_i;
  assign ov_lock_en_o    = ctrl.ov_lock_en;
  assign off_time_sel_o  = ctrl.off_time;
  assign fast_decay_o    = ctrl.fast_decay;
  assign cur_limit_sel_o = ctrl.cur_limit;

  // R10
  idle_sclk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl[1] && !rise[1]) |=> !commit);
endmodule

// File: tb/mbc_serial_ctrl_test.sv
module mbc_serial_ctrl_test;
  localparam int H = 8;  // clk cycles per serial half period

  logic clk = 0, rst_ni = 0;
  logic sclk = 0, csn = 1, sdi = 0;
  logic sf = 0, ss = 0, sg = 0, ol = 0;
  logic [1:0] temp = 0;
  logic sdo, sdo_en, ovl, fast, clr;
  logic [1:0] offt, curl;
  int checks = 0, fails = 0, clr_cnt = 0;
  bit done = 0;
  logic [7:0] exp_ctrl = 0;

  always #4 clk = ~clk;

  mbc_serial_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_en_o(sdo_en),
    .supply_fail_i(sf), .short_supply_i(ss), .short_gnd_i(sg), .open_load_i(ol),
    .temp_level_i(temp),
    .ov_lock_en_o(ovl), .off_time_sel_o(offt), .fast_decay_o(fast),
    .cur_limit_sel_o(curl), .status_clr_o(clr)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // per-clock pad enable model (R2)
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      checks++;
      if (sdo_en !== !csn) begin
        fails++;
        $display("FAIL R2: sdo_en %b expected %b", sdo_en, !csn);
      end
    end
    if (clr === 1'b1) clr_cnt++;
  end

  function automatic logic [7:0] diag_now();
    logic e = sf | ss | sg | ol | (temp != 0);
    return {sf, 1'b1, ss, sg, ol, temp, e};
  endfunction

  function automatic logic [7:0] ctrl_view();
    return {1'b0, ovl, 1'b0, offt, fast, curl};
  endfunction

  function automatic logic [7:0] ctrl_of(input logic [7:0] w);
    return {1'b0, w[6], 1'b0, w[4:3], w[2], w[1:0]};
  endfunction

  task automatic frame(input logic [31:0] tx, input int n, output logic [31:0] rx);
    rx = 0;
    @(negedge clk); csn = 0;
    repeat (H) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      sclk = 1; sdi = tx[k];
      repeat (H) @(negedge clk);
      rx[k] = sdo;
      sclk = 0;
      repeat (H) @(negedge clk);
    end
    csn = 1;
    repeat (H) @(negedge clk);
  endtask

  task automatic run(input string req, input logic [31:0] tx, input int n, input int exp_clr);
    logic [31:0] rx, exp_rx;
    logic [7:0] d;
    int q[$];
    d = diag_now();
    for (int k = 0; k < 8; k++) q.push_back(int'(d[k]));
    for (int k = 0; k < n; k++) q.push_back(int'(tx[k]));
    exp_rx = 0;
    for (int k = 0; k < n; k++) exp_rx[k] = q[k][0];
    clr_cnt = 0;
    frame(tx, n, rx);
    check({req, " sdo"}, rx, exp_rx);
    if (n >= 8) exp_ctrl = ctrl_of(8'(tx >> (n - 8)));
    check({req, " ctrl"}, {24'd0, ctrl_view()}, {24'd0, exp_ctrl});
    check({req, " R7 clr"}, clr_cnt, exp_clr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ctrl", {24'd0, ctrl_view()}, 0);
    check("R1 clr", clr, 0);
    check("R2 released", sdo_en, 0);
    rst_ni = 1;
    repeat (4) @(negedge clk);

    // R3 R4 R5: supply fail only, diag C1
    sf = 1;
    run("R3 R4 R5 w5B", 32'h5B, 8, 0);
    // R3 bit5 ignored, R7 pulse, R5 temp+open load -> 4D
    sf = 0; temp = 2'b10; ol = 1;
    run("R3 R5 R7 wB4", 32'hB4, 8, 1);
    // R5 no faults: flag 0 despite constant bit 6
    temp = 0; ol = 0;
    run("R5 w26", 32'h26, 8, 0);
    // R8 partial frame
    run("R8 partial", 32'hFF, 5, 0);

    // R6 peek
    @(negedge clk); csn = 0;
    repeat (H) @(negedge clk);
    check("R6 peek clear", sdo, 0);
    sg = 1;
    repeat (4) @(negedge clk);
    check("R6 peek live", sdo, 1);
    csn = 1;
    repeat (H) @(negedge clk);
    check("R6 ctrl unchanged", {24'd0, ctrl_view()}, {24'd0, exp_ctrl});
    sg = 0;

    // R9 chained 16-clock frame, short to supply -> diag 61
    ss = 1;
    run("R9 chain", 32'hC319, 16, 1);
    ss = 0;

    // R10 serial clocks while deselected
    sdi = 1;
    for (int k = 0; k < 3; k++) begin
      sclk = 1; repeat (H) @(negedge clk);
      sclk = 0; repeat (H) @(negedge clk);
    end
    check("R10 ctrl idle", {24'd0, ctrl_view()}, {24'd0, exp_ctrl});
    run("R10 after idle", 32'h00, 8, 0);

    // R1 reset mid-run
    run("R3 w59", 32'h59, 8, 0);
    rst_ni = 0;
    @(negedge clk);
    check("R1 reset again", {24'd0, ctrl_view()}, 0);
    rst_ni = 1;
    exp_ctrl = 0;
    run("R8 after reset", 32'h7F, 7, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule